// File: doc/BRIEF.md
# Built-In Self-Test Harness with Signature Compaction

This block runs a complete self-test session on a small arithmetic circuit. A start request loads a 4-bit pseudorandom pattern generator and clears a 4-bit signature register. For fifteen cycles, each pattern is split into two 2-bit operands and fed to a 2x2 carry-save array multiplier. Each cycle, the four product bits are folded into the signature register. When the session ends, the final signature is compared with a golden value supplied as a parameter, and the block reports pass or fail.

A test-only fault input forces one chosen product bit to a fixed value for the whole session. This lets the harness show that it detects a broken multiplier. No data stream crosses the block boundary, so every pin is a plain control or status signal and there is no valid/ready handshake. The start request is level-sampled while the block is idle and ignored while a session is running.

Top module: `bist_harness`

## Requirements
- R1: While reset is held and in the first cycle after reset, busy, done, pass and fail are all low.
- R2: When start is high at a clock edge while the block is idle, busy rises after that edge and stays high for exactly 16 cycles.
- R3: A start request made while busy is high has no effect: the session length and its verdict are unchanged.
- R4: The pattern generator is loaded with 4'b0001 at session start. Each session cycle it advances as next = {s[2:0], s[3]^s[2]} (polynomial 1 + x^3 + x^4) and delivers 15 patterns. Operand A is s[3:2] and operand B is s[1:0].
- R5: The circuit under test produces the 4-bit product P = A*B from AND partial products and two half adders. P[0] is the least significant bit.
- R6: The signature register is cleared to 4'b0000 at session start. For each pattern it updates as m = {m[2:0], m[3]^m[2]} ^ P.
- R7: done is high for exactly one cycle, in the cycle right after busy falls.
- R8: When done rises, pass is set if the final signature equals GOLDEN and fail is set otherwise. The default GOLDEN (4'b0100) is the fault-free signature. pass and fail are never both high.
- R9: pass and fail are low while busy is high. They keep their value from the end of a session until the next accepted start.
- R10: When fault_en is high, product bit fault_sel (0 = P[0]) is forced to fault_val before compaction. When fault_en is low, the fault inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a session when idle |
| fault_en | input | 1 | Enable stuck-at injection on the product |
| fault_sel | input | 2 | Index of the product bit to force |
| fault_val | input | 1 | Value the selected product bit is forced to |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle end-of-session pulse |
| pass | output | 1 | Final signature matched the golden value |
| fail | output | 1 | Final signature differed from the golden value |

## Verification
The main function is first run fault-free. This shows that pattern order, multiplier and compaction all line up with the golden signature. It is then run with every product bit stuck at 0 and then at 1. Each of those eight sessions shows whether that bit's contribution actually reaches the signature. The expected verdict of each faulty run comes from a behavioural model that computes the faulty signature, so a fault that aliases to the golden value is predicted correctly rather than assumed to fail. Repeated starts during a session, and long idle gaps after a verdict, separate correct start qualification and result holding from a controller that restarts or clears its result.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int REG_W  = 4;
  localparam int OP_W   = 2;
  localparam int PROD_W = 2 * OP_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_CHECK = 2'd2
  } sess_state_t;
endpackage

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
  parameter int              W    = 4,
  parameter logic [W-1:0]    TAPS = 4'b1100,
  parameter logic [W-1:0]    SEED = 4'b0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED;
    else if (load) state <= SEED;
    else if (step) state <= {state[W-2:0], fb};
  end
endmodule

// File: rtl/bist_braun_mul.sv
module bist_braun_mul #(
  parameter int N = 2
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  logic [N-1:0] pp [N];

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      assign pp[i][j] = a[i] & b[j];
    end
  end

  // carry-save row for the 2x2 array: n*(n-1) = 2 adders
  logic c1;
  assign p[0] = pp[0][0];
  assign p[1] = pp[1][0] ^ pp[0][1];
  assign c1   = pp[1][0] & pp[0][1];
  assign p[2] = pp[1][1] ^ c1;
  assign p[3] = pp[1][1] & c1;
endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
  parameter int           W    = 4,
  parameter logic [W-1:0] TAPS = 4'b1100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig
);
  logic fb;
  assign fb = ^(sig & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sig <= '0;
    else if (clear) sig <= '0;
    else if (step)  sig <= {sig[W-2:0], fb} ^ din;
  end
endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
  import bist_pkg::*;
#(
  parameter int           NUM_PATTERNS = 15,
  parameter logic [REG_W-1:0] GOLDEN   = 4'b0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [REG_W-1:0] sig,
  output logic             load,
  output logic             step,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic             fail
);
  localparam int CNT_W = $clog2(NUM_PATTERNS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_PATTERNS - 1);

  sess_state_t      st;
  logic [CNT_W-1:0] cnt;

  assign load = (st == ST_IDLE) && start;
  assign step = (st == ST_RUN);
  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      done <= 1'b0;
      pass <= 1'b0;
      fail <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          st   <= ST_RUN;
          cnt  <= '0;
          pass <= 1'b0;
          fail <= 1'b0;
        end
        ST_RUN: begin
          if (cnt == LAST) st <= ST_CHECK;
          else             cnt <= cnt + 1'b1;
        end
        ST_CHECK: begin
          st   <= ST_IDLE;
          done <= 1'b1;
          pass <= (sig == GOLDEN);
          fail <= (sig != GOLDEN);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bist_harness.sv
module bist_harness
  import bist_pkg::*;
#(
  parameter int               NUM_PATTERNS = 15,
  parameter logic [REG_W-1:0] GOLDEN       = 4'b0100
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      fault_en,
  input  logic [$clog2(PROD_W)-1:0] fault_sel,
  input  logic                      fault_val,
  output logic                      busy,
  output logic                      done,
  output logic                      pass,
  output logic                      fail
);
  logic              load, step;
  logic [REG_W-1:0]  pat;
  logic [PROD_W-1:0] prod, prod_obs, fmask;
  logic [REG_W-1:0]  sig;

  bist_ctrl #(.NUM_PATTERNS(NUM_PATTERNS), .GOLDEN(GOLDEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .sig(sig),
    .load(load), .step(step), .busy(busy), .done(done),
    .pass(pass), .fail(fail)
  );

  bist_lfsr #(.W(REG_W), .TAPS(4'b1100), .SEED(4'b0001)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .state(pat)
  );

  bist_braun_mul #(.N(OP_W)) u_cut (
    .a(pat[REG_W-1:OP_W]), .b(pat[OP_W-1:0]), .p(prod)
  );

  // stuck-at injection on one product bit
  assign fmask    = PROD_W'(1) << fault_sel;
  assign prod_obs = fault_en ? ((prod & ~fmask) | (fault_val ? fmask : '0)) : prod;

  bist_misr #(.W(REG_W), .TAPS(4'b1100)) u_misr (
    .clk(clk), .rst_n(rst_n), .clear(load), .step(step),
    .din(prod_obs), .sig(sig)
  );
endmodule

// File: rtl/bist_harness_chk.sv
module bist_harness_chk #(
  parameter int NUM_PATTERNS = 15
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic pass,
  input logic fail
);
  localparam int SESS_LEN = NUM_PATTERNS + 1;
  int unsigned busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= 0;
    else if (busy) busy_cnt <= busy_cnt + 1;
    else           busy_cnt <= 0;
  end

  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2
  sess_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == SESS_LEN));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  // R8
  verdict_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass || fail));

  // R9
  quiet_in_sess_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!pass && !fail));

  // R9
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(pass) && $stable(fail)));
endmodule

bind bist_harness bist_harness_chk #(.NUM_PATTERNS(NUM_PATTERNS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .pass(pass), .fail(fail)
);

// File: tb/bist_harness_bench.sv
module bist_harness_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       fault_en = 1'b0;
  logic [1:0] fault_sel = 2'd0;
  logic       fault_val = 1'b0;
  logic       busy, done, pass, fail;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  bist_harness u_bist_harness (
    .clk(clk), .rst_n(rst_n), .start(start), .fault_en(fault_en),
    .fault_sel(fault_sel), .fault_val(fault_val),
    .busy(busy), .done(done), .pass(pass), .fail(fail)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural model of R4, R5, R6, R10
  function automatic logic [3:0] model_sig(input logic en, input logic [1:0] sel, input logic val);
    logic [3:0] s = 4'b0001;
    logic [3:0] m = 4'b0000;
    logic [3:0] p;
    for (int k = 0; k < 15; k++) begin
      p = 4'(s[3:2] * s[1:0]);
      if (en) p[sel] = val;
      m = {m[2:0], m[3] ^ m[2]} ^ p;
      s = {s[2:0], s[3] ^ s[2]};
    end
    return m;
  endfunction

  // run a session; optional extra start pulse at busy cycle mid_start (0 = none)
  task automatic run_session(input logic en, input logic [1:0] sel, input logic val,
                             input int mid_start, input string tag);
    int n = 0;
    logic exp_pass;
    exp_pass = (model_sig(en, sel, val) == model_sig(1'b0, 2'd0, 1'b0));
    @(negedge clk);
    fault_en = en; fault_sel = sel; fault_val = val; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R2 busy after start"}, busy, 1'b1);
    while (busy && n < 100) begin
      n++;
      if (!(pass === 1'b0 && fail === 1'b0)) check({tag, " R9 verdict low in session"}, {pass, fail}, 2'b00);
      if (n == mid_start) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    check({tag, " R2 R3 busy length"}, n, 16);
    check({tag, " R7 done pulse"}, done, 1'b1);
    check({tag, " R8 R10 pass"}, pass, exp_pass);
    check({tag, " R8 R10 fail"}, fail, !exp_pass);
    @(negedge clk);
    check({tag, " R7 done one cycle"}, done, 1'b0);
  endtask

  task automatic t_reset;
    #1;
    check("R1 reset busy", busy, 1'b0);
    check("R1 reset flags", {done, pass, fail}, 3'b000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset", {busy, done, pass, fail}, 4'b0000);
  endtask

  task automatic t_clean;
    check("R4 R5 R6 model golden", model_sig(1'b0, 2'd0, 1'b0), 4'b0100);
    run_session(1'b0, 2'd0, 1'b0, 0, "clean");
  endtask

  task automatic t_faults;
    for (int b = 0; b < 4; b++) begin
      for (int v = 0; v < 2; v++) begin
        run_session(1'b1, 2'(b), 1'(v), 0, $sformatf("R10 stuck p%0d=%0d", b, v));
      end
    end
    // fault inputs ignored when disabled
    run_session(1'b0, 2'd2, 1'b1, 0, "R10 disabled");
  endtask

  task automatic t_start_busy;
    run_session(1'b0, 2'd0, 1'b0, 7, "R3 restart ignored");
    run_session(1'b1, 2'd1, 1'b1, 3, "R3 restart ignored faulty");
  endtask

  task automatic t_hold;
    logic exp_p;
    exp_p = pass;
    fault_en = 1'b0;
    repeat (20) @(negedge clk);
    check("R9 hold pass", pass, exp_p);
    check("R9 hold fail", fail, !exp_p);
    check("R9 idle stays", {busy, done}, 2'b00);
  endtask

  initial begin
    t_reset();
    t_clean();
    t_faults();
    t_hold();
    t_start_busy();
    run_session(1'b0, 2'd0, 1'b0, 0, "R8 clean after faults");
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule